// File: doc/BRIEF.md
# Transitive Checkpoint Group Resolver

This block works out which processors must act together when one processor starts a checkpoint or a rollback. Each processor keeps two dependence bitmaps: the processors whose data it has consumed (its producers) and the processors that have consumed its data (its consumers). Before a checkpoint, every processor that fed data to the initiator must also checkpoint, and so must the processors that fed them, and so on. Before a rollback, every processor that consumed the initiator's data must also roll back, again transitively.

A start pulse captures one set of bitmaps: the producer maps in checkpoint mode, the consumer maps in rollback mode. The resolver then grows a member set outward from the initiator one layer per clock, until a layer adds nobody. It then publishes the set on a registered output with a one-cycle done pulse. The surrounding logic uses the set to tell each member to act.

Top module: `ckg_group_resolver`

## Requirements
- R1: During reset and in the first cycle after it, busy, done and the group output are all zero.
- R2: With mode 0 (checkpoint), the group is the initiator plus the transitive closure over the producer maps. Bit j of row i (flat bit i*NPROC+j) set means processor j is a producer of processor i.
- R3: With mode 1 (rollback), the group is formed the same way from the consumer maps, using the same row and bit layout. The producer maps have no effect in this mode.
- R4: A processor added to the group has its own row expanded in turn. Cycles in the maps end the expansion without repeating members.
- R5: The initiator's bit is always set in the group, even when every map row is empty.
- R6: A start accepted at an edge raises busy for L+1 cycles, where L is the number of expansion layers that add members. At the edge where busy falls, done rises for exactly one cycle and the group output takes the new set.
- R7: Busy never lasts more than NPROC cycles for one resolution.
- R8: A start pulse while busy is ignored. It changes neither the running resolution nor its result.
- R9: The maps and mode are sampled at the accepted start. Changes to them while busy do not affect the result.
- R10: The group output changes only at a done pulse. It holds its value while idle and throughout the next resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a resolution (taken only when idle) |
| mode_i | input | 1 | 0 = checkpoint (producer maps), 1 = rollback (consumer maps) |
| init_idx_i | input | IDXW | Index of the initiating processor |
| prod_map_i | input | NPROC*NPROC | Producer rows; row i at bits i*NPROC +: NPROC |
| cons_map_i | input | NPROC*NPROC | Consumer rows; same layout |
| busy_o | output | 1 | Resolution in progress |
| done_o | output | 1 | One-cycle completion pulse |
| group_o | output | NPROC | Registered member set of the last resolution |

## Verification
The bench targets several corner cases:
- Empty maps: a design that drops the initiator bit would report an empty group.
- A chain of NPROC members: a design with an iteration cap set too low would return a truncated set, and its busy count would differ from the model.
- Mutual producer cycles: a design that re-expands old members would never stop.
- Rollback mode with busy producer maps: a design that selects the wrong map would return the producers.
- A second start, and map changes, during a busy resolution: a design that does not hold the captured rows would return a different group or restart its busy window.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic {
    CKG_CHECKPOINT = 1'b0,
    CKG_ROLLBACK   = 1'b1
  } ckg_mode_e;
endpackage

// File: rtl/ckg_rel_store.sv
module ckg_rel_store #(
  parameter int NPROC = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic                     busy_i,
  input  logic                     mode_i,
  input  logic [NPROC*NPROC-1:0]   prod_map_i,
  input  logic [NPROC*NPROC-1:0]   cons_map_i,
  output logic [NPROC*NPROC-1:0]   rel_flat_o
);
  import ckg_pkg::*;
  localparam int FLATW = NPROC * NPROC;

  logic [NPROC-1:0] rel_q [NPROC];

  for (genvar r = 0; r < NPROC; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        rel_q[r] <= '0;
      end else if (load_i) begin
        if (ckg_mode_e'(mode_i) == CKG_ROLLBACK)
          rel_q[r] <= cons_map_i[r*NPROC +: NPROC];
        else
          rel_q[r] <= prod_map_i[r*NPROC +: NPROC];
      end
    end
    assign rel_flat_o[r*NPROC +: NPROC] = rel_q[r];
  end

  logic [FLATW-1:0] rel_chk;
  assign rel_chk = rel_flat_o;

  // R9: captured rows hold across every busy cycle
  assert_rows_held_R9: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(rel_chk));
endmodule

// File: rtl/ckg_expand.sv
module ckg_expand #(
  parameter int NPROC = 8
) (
  input  logic [NPROC*NPROC-1:0] rel_flat_i,
  input  logic [NPROC-1:0]       frontier_i,
  input  logic [NPROC-1:0]       member_i,
  output logic [NPROC-1:0]       fresh_o
);
  logic [NPROC-1:0] masked [NPROC];
  logic [NPROC-1:0] reach  [NPROC+1];

  assign reach[0] = '0;
  for (genvar r = 0; r < NPROC; r++) begin : g_or
    assign masked[r]  = frontier_i[r] ? rel_flat_i[r*NPROC +: NPROC] : '0;
    assign reach[r+1] = reach[r] | masked[r];
  end

  assign fresh_o = reach[NPROC] & ~member_i;
endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl #(
  parameter int NPROC = 8,
  parameter int IDXW  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [IDXW-1:0]  init_idx_i,
  input  logic [NPROC-1:0] fresh_i,
  output logic             load_o,
  output logic [NPROC-1:0] frontier_o,
  output logic [NPROC-1:0] member_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [NPROC-1:0] group_o
);
  localparam int CNTW = $clog2(NPROC + 1) + 1;

  logic             busy_q, done_q;
  logic [NPROC-1:0] member_q, frontier_q, group_q;
  logic [IDXW-1:0]  init_q;
  logic [CNTW-1:0]  iter_q;
  logic [NPROC-1:0] seed;

  assign seed   = {{(NPROC-1){1'b0}}, 1'b1} << init_idx_i;
  assign load_o = start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      member_q   <= '0;
      frontier_q <= '0;
      group_q    <= '0;
      init_q     <= '0;
      iter_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q     <= 1'b1;
        member_q   <= seed;
        frontier_q <= seed;
        init_q     <= init_idx_i;
        iter_q     <= CNTW'(1);
      end else if (busy_q) begin
        if (fresh_i == '0) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          group_q    <= member_q;
          frontier_q <= '0;
        end else begin
          member_q   <= member_q | fresh_i;
          frontier_q <= fresh_i;
          iter_q     <= iter_q + CNTW'(1);
        end
      end
    end
  end

  assign frontier_o = frontier_q;
  assign member_o   = member_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign group_o    = group_q;

  // R6: done only while idle, and only for one cycle
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R7: iteration counter bounded by processor count
  assert_iter_bound_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (iter_q <= CNTW'(NPROC)));
  // R5: initiator present in every published group
  assert_init_member_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> group_q[init_q]);
  // R4: the frontier is always inside the member set
  assert_frontier_inside_R4: assert property (@(posedge clk) disable iff (rst)
    (frontier_q & ~member_q) == '0);
  // R10: the group output moves only with a done pulse
  assert_group_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(group_q));
endmodule

// File: rtl/ckg_group_resolver.sv
module ckg_group_resolver #(
  parameter int NPROC = 8,
  parameter int IDXW  = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   mode_i,
  input  logic [IDXW-1:0]        init_idx_i,
  input  logic [NPROC*NPROC-1:0] prod_map_i,
  input  logic [NPROC*NPROC-1:0] cons_map_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [NPROC-1:0]       group_o
);
  localparam int FLATW = NPROC * NPROC;

  logic             load;
  logic [FLATW-1:0] rel_flat;
  logic [NPROC-1:0] frontier, member, fresh;

  ckg_rel_store #(.NPROC(NPROC)) store_i (
    .clk(clk), .rst(rst), .load_i(load), .busy_i(busy_o), .mode_i(mode_i),
    .prod_map_i(prod_map_i), .cons_map_i(cons_map_i), .rel_flat_o(rel_flat)
  );

  ckg_expand #(.NPROC(NPROC)) expand_i (
    .rel_flat_i(rel_flat), .frontier_i(frontier), .member_i(member),
    .fresh_o(fresh)
  );

  ckg_ctrl #(.NPROC(NPROC), .IDXW(IDXW)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i), .init_idx_i(init_idx_i),
    .fresh_i(fresh), .load_o(load), .frontier_o(frontier), .member_o(member),
    .busy_o(busy_o), .done_o(done_o), .group_o(group_o)
  );

  // R8: a start while busy does not end or restart the resolution
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/ckg_group_resolver_tb_top.sv
module ckg_group_resolver_tb_top;
  localparam int NP = 8;
  localparam int CLK_PERIOD = 10;
  localparam int FW = NP * NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [2:0]    init_idx = '0;
  logic [FW-1:0] pmap = '0;
  logic [FW-1:0] cmap = '0;
  logic          busy, done;
  logic [NP-1:0] group;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckg_group_resolver #(.NPROC(NP)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
    .init_idx_i(init_idx), .prod_map_i(pmap), .cons_map_i(cmap),
    .busy_o(busy), .done_o(done), .group_o(group)
  );

  function automatic void closure(input logic [FW-1:0] maps, input int ini,
                                  output logic [NP-1:0] grp, output int layers);
    logic [NP-1:0] front, nxt;
    grp = '0; grp[ini] = 1'b1; front = grp; layers = 0;
    forever begin
      nxt = '0;
      for (int i = 0; i < NP; i++)
        if (front[i])
          for (int j = 0; j < NP; j++)
            if (maps[i*NP+j]) nxt[j] = 1'b1;
      nxt = nxt & ~grp;
      if (nxt == '0) break;
      grp = grp | nxt;
      front = nxt;
      layers++;
    end
  endfunction

  // behavioural reference model
  bit            m_busy = 0, m_done = 0;
  logic [NP-1:0] m_group = '0, m_pend = '0;
  int            m_left = 0;

  always @(posedge clk) begin
    int lay;
    logic [NP-1:0] g;
    if (rst) begin
      m_busy = 0; m_done = 0; m_group = '0; m_left = 0;
    end else begin
      m_done = 0;
      if (start && !m_busy) begin
        closure(mode ? cmap : pmap, int'(init_idx), g, lay);
        m_pend = g; m_left = lay + 1; m_busy = 1;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_group = m_pend;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R6 busy vs model", 32'(busy), 32'(m_busy));
      check("R6 done vs model", 32'(done), 32'(m_done));
      check("R2 group vs model", 32'(group), 32'(m_group));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [FW-1:0] link(input logic [FW-1:0] m, input int row, input int col);
    logic [FW-1:0] r;
    r = m; r[row*NP+col] = 1'b1;
    return r;
  endfunction

  int busy_cnt;

  task automatic launch(input bit md, input int ini);
    @(negedge clk);
    mode = md; init_idx = 3'(ini); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_wait();
    busy_cnt = 0;
    while (!done) begin
      if (busy) busy_cnt++;
      @(negedge clk);
    end
  endtask

  task automatic resolve(input bit md, input int ini);
    launch(md, ini);
    finish_wait();
  endtask

  initial begin
    logic [NP-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 0);
    check("R1 done in reset", 32'(done), 0);
    check("R1 group in reset", 32'(group), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 group after reset", 32'(group), 0);
    check("R1 busy after reset", 32'(busy), 0);

    // R5: empty maps
    resolve(0, 3);
    check("R5 initiator only", 32'(group), 32'h08);
    check("R6 busy cycles empty", 32'(busy_cnt), 1);

    // R2/R4: producer chain 1->{2,3}, 2->{4}, 0->{7}
    pmap = '0;
    pmap = link(pmap, 1, 2); pmap = link(pmap, 1, 3);
    pmap = link(pmap, 2, 4); pmap = link(pmap, 0, 7);
    cmap = '0;
    cmap = link(cmap, 1, 5); cmap = link(cmap, 5, 6);
    resolve(0, 1);
    check("R2 checkpoint group", 32'(group), 32'h1E);
    check("R4 transitive reach", 32'(group[4]), 1);
    check("R6 busy cycles two layers", 32'(busy_cnt), 3);
    @(negedge clk);
    check("R6 done single cycle", 32'(done), 0);

    // R3: rollback via consumer rows
    resolve(1, 1);
    check("R3 rollback group", 32'(group), 32'h62);

    // R4: mutual cycle 2<->3
    pmap = '0; pmap = link(pmap, 2, 3); pmap = link(pmap, 3, 2);
    resolve(0, 2);
    check("R4 cycle terminates", 32'(group), 32'h0C);

    // R7: full chain i -> i+1
    pmap = '0;
    for (int i = 0; i < NP-1; i++) pmap = link(pmap, i, i+1);
    resolve(0, 0);
    check("R7 full chain group", 32'(group), 32'hFF);
    check("R7 busy cycles bound", 32'(busy_cnt), NP);

    // R8/R9/R10: restart attempt and map changes while busy
    held = group;
    launch(0, 0);
    check("R10 group held while busy", 32'(group), 32'(held));
    @(negedge clk);
    start = 1'b1; init_idx = 3'd5;
    pmap = '0; mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 group held mid-run", 32'(group), 32'(held));
    finish_wait();
    check("R8 restart ignored busy cycles", 32'(busy_cnt), NP - 2);
    check("R9 sampled rows used", 32'(group), 32'hFF);

    repeat (4) @(negedge clk);
    check("R10 group stable idle", 32'(group), 32'hFF);

    // rollback with producer rows non-empty must ignore them (R3)
    pmap = '1; cmap = '0;
    resolve(1, 6);
    check("R3 producers ignored", 32'(group), 32'h40);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule